// File: doc/BRIEF.md
# Latency-Matched Divide-and-Add Pipeline

This block evaluates `x + y / z` on unsigned operands that all share the width `WIDTH`, and it takes a fresh operand set on every clock cycle. The quotient comes from a pipelined restoring divider. The number of divider stages is worked out from `WIDTH` itself. The addend `x` travels down a delay line of that same depth, so each `x` arrives at the final registered adder in the same cycle as the quotient of its own operand set. The sum is one bit wider than the operands so that the carry is kept.

The divider depth is also driven onto a constant output port. A parent can align its own side paths to that port without reaching into a child's parameters. The stream interface is a plain valid strobe in both directions, with no ready signal. The block never stalls, and downstream logic must accept a result in the cycle it is presented. A divisor of zero does not trap: the quotient saturates to all ones and a flag is raised alongside that result.

Top module: `ddiv_top`

## Requirements
- R1: For a nonzero divisor, the result on `sum_out` (WIDTH+1 bits) equals `x_in + floor(y_in / z_in)` of the accepted operand set.
- R2: `latency_out` carries the divider depth `max(1, WIDTH >> 1)` at all times. With the default WIDTH of 8 this value is 4.
- R3: `out_valid` is high exactly `latency + 1` clock cycles after `in_valid` was sampled high. Back-to-back sets and sets separated by gaps each produce one result, in the order they were accepted.
- R4: When `z_in` is 0, the quotient is taken as all ones, so the result is `x_in + 2^WIDTH - 1`, and `div_zero` is high in the cycle that result is valid.
- R5: `div_zero` is low whenever `out_valid` is low, and it is low for results whose divisor was nonzero.
- R6: Synchronous active-high `rst` forces `out_valid` low from the next edge onward and discards every operand set still in flight. Operand sets presented while `rst` is high produce no result.
- R7: While `out_valid` is low, `sum_out` keeps the value of the most recent result. Reset does not clear it.
- R8: The largest operands (`x` all ones, `y` all ones, `z` = 1) give `2^(WIDTH+1) - 2` without loss of the carry bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set present this cycle |
| x_in | input | WIDTH | Addend |
| y_in | input | WIDTH | Dividend |
| z_in | input | WIDTH | Divisor |
| out_valid | output | 1 | Result present this cycle |
| sum_out | output | WIDTH+1 | x + y/z of the matching operand set |
| div_zero | output | 1 | Result was produced with a zero divisor |
| latency_out | output | LAT_W | Constant divider depth in cycles |

## Verification
The hardest case to reach is a reset that arrives while the pipeline is full of mixed sets, some of them zero-divisor sets. The reset must cancel every set in flight, and the adder must still hold its last sum. The bench first streams back-to-back random sets with a zero divisor mixed in. It raises reset in the middle of that stream while keeping `in_valid` high, so sets offered during reset are also checked to vanish. A reference queue keyed by cycle predicts every output on every clock, so a result that appears at the wrong depth or with another set's `x` shows up at once.

// File: rtl/ddiv_pkg.sv
package ddiv_pkg;
  function automatic int div_depth(input int w);
    return ((w >> 1) < 1) ? 1 : (w >> 1);
  endfunction

  function automatic int bits_per_stage(input int w);
    int d;
    d = div_depth(w);
    return (w + d - 1) / d;
  endfunction

  function automatic int depth_width(input int w);
    int d;
    d = div_depth(w);
    return ($clog2(d + 1) < 1) ? 1 : $clog2(d + 1);
  endfunction
endpackage

// File: rtl/ddiv_step.sv
module ddiv_step #(
  parameter int WIDTH     = 8,
  parameter int BPS       = 2,
  parameter int FIRST_IDX = 0
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] dvd_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic [WIDTH-1:0] rem_o,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] dvd_o,
  output logic [WIDTH-1:0] dvs_o
);
  logic [WIDTH-1:0] r_n, q_n, d_n;
  logic [WIDTH:0]   trial;

  // Restoring division: each step moves one dividend bit into the partial remainder
  always_comb begin
    r_n   = rem_i;
    q_n   = quo_i;
    d_n   = dvd_i;
    trial = '0;
    for (int k = 0; k < BPS; k++) begin
      if (FIRST_IDX + k < WIDTH) begin
        trial = {r_n, d_n[WIDTH-1]};
        d_n   = d_n << 1;
        q_n   = q_n << 1;
        if (trial >= {1'b0, dvs_i}) begin
          trial  = trial - {1'b0, dvs_i};
          q_n[0] = 1'b1;
        end
        r_n = trial[WIDTH-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    rem_o <= r_n;
    quo_o <= q_n;
    dvd_o <= d_n;
    dvs_o <= dvs_i;
  end
endmodule

// File: rtl/ddiv_align.sv
module ddiv_align #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_i,
  input  logic [WIDTH-1:0] x_i,
  input  logic             dz_i,
  output logic             v_o,
  output logic [WIDTH-1:0] x_o,
  output logic             dz_o
);
  logic [DEPTH-1:0]            v_sr;
  logic [DEPTH-1:0][WIDTH-1:0] x_sr;
  logic [DEPTH-1:0]            dz_sr;

  always_ff @(posedge clk) begin
    if (rst) v_sr[0] <= 1'b0;
    else     v_sr[0] <= v_i;
    x_sr[0]  <= x_i;
    dz_sr[0] <= dz_i;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) v_sr[s] <= 1'b0;
      else     v_sr[s] <= v_sr[s-1];
      x_sr[s]  <= x_sr[s-1];
      dz_sr[s] <= dz_sr[s-1];
    end
  end

  assign v_o  = v_sr[DEPTH-1];
  assign x_o  = x_sr[DEPTH-1];
  assign dz_o = dz_sr[DEPTH-1];
endmodule

// File: rtl/ddiv_top.sv
module ddiv_top
  import ddiv_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int LAT_W = depth_width(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic [WIDTH-1:0] z_in,
  output logic             out_valid,
  output logic [WIDTH:0]   sum_out,
  output logic             div_zero,
  output logic [LAT_W-1:0] latency_out
);
  localparam int LAT = div_depth(WIDTH);
  localparam int BPS = bits_per_stage(WIDTH);

  logic [LAT:0][WIDTH-1:0] rem_c, quo_c, dvd_c, dvs_c;
  logic             al_v, al_dz;
  logic [WIDTH-1:0] al_x;
  logic             dz_q;

  assign rem_c[0] = '0;
  assign quo_c[0] = '0;
  assign dvd_c[0] = y_in;
  assign dvs_c[0] = z_in;

  for (genvar s = 0; s < LAT; s++) begin : g_div
    ddiv_step #(
      .WIDTH(WIDTH), .BPS(BPS), .FIRST_IDX(s * BPS)
    ) u_step (
      .clk(clk),
      .rem_i(rem_c[s]),   .quo_i(quo_c[s]),
      .dvd_i(dvd_c[s]),   .dvs_i(dvs_c[s]),
      .rem_o(rem_c[s+1]), .quo_o(quo_c[s+1]),
      .dvd_o(dvd_c[s+1]), .dvs_o(dvs_c[s+1])
    );
  end

  ddiv_align #(.WIDTH(WIDTH), .DEPTH(LAT)) u_align (
    .clk(clk), .rst(rst),
    .v_i(in_valid), .x_i(x_in), .dz_i(z_in == '0),
    .v_o(al_v), .x_o(al_x), .dz_o(al_dz)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= al_v;
    if (al_v && !rst) begin
      sum_out <= {1'b0, al_x} + {1'b0, quo_c[LAT]};
      dz_q    <= al_dz;
    end
  end

  assign div_zero    = dz_q & out_valid;
  assign latency_out = LAT_W'(LAT);
endmodule

// File: rtl/ddiv_chk.sv
module ddiv_chk #(
  parameter int WIDTH = 8,
  parameter int LAT   = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           out_valid,
  input logic           div_zero,
  input logic [WIDTH:0] sum_out
);
  int pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 0;
    else     pend <= pend + (in_valid ? 1 : 0) - (out_valid ? 1 : 0);
  end

  // R6
  reset_flush_chk: assert property (@(posedge clk) rst |=> !out_valid);
  // R5
  flag_gated_chk: assert property (@(posedge clk) disable iff (rst) !out_valid |-> !div_zero);
  // R3
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst) pend <= LAT + 1);
  // R3
  no_orphan_chk: assert property (@(posedge clk) disable iff (rst) out_valid |-> pend != 0);
  // R7
  hold_sum_chk: assert property (@(posedge clk) disable iff (rst) !out_valid |-> $stable(sum_out));
endmodule

bind ddiv_top ddiv_chk #(.WIDTH(WIDTH), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .div_zero(div_zero), .sum_out(sum_out)
);

// File: tb/tb_ddiv_top.sv
module tb_ddiv_top;
  localparam int W   = 8;
  localparam int LAT = 4;
  localparam int RING = 16;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [W-1:0] x_in = 0, y_in = 0, z_in = 1;
  logic out_valid, div_zero;
  logic [W:0] sum_out;
  logic [2:0] latency_out;

  int checks = 0, errors = 0, cyc = 0;
  bit exp_v [RING];
  int exp_s [RING];
  bit exp_dz[RING];
  int last_sum = 0;
  bit have_last = 0;

  always #5 clk = ~clk;

  ddiv_top #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .out_valid(out_valid), .sum_out(sum_out),
    .div_zero(div_zero), .latency_out(latency_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit r, input bit v, input int x, input int y, input int z);
    int i, o;
    @(negedge clk);
    i = cyc % RING;
    // R3 / R6: valid timing and flush
    chk(out_valid == exp_v[i], "R3/R6 out_valid", out_valid, exp_v[i]);
    if (exp_v[i]) begin
      // R1 / R4 / R8 value
      chk(sum_out == exp_s[i], "R1/R4/R8 sum_out", sum_out, exp_s[i]);
      // R4 / R5 flag
      chk(div_zero == exp_dz[i], "R4/R5 div_zero", div_zero, exp_dz[i]);
      last_sum = exp_s[i];
      have_last = 1;
    end else begin
      chk(div_zero == 0, "R5 div_zero idle", div_zero, 0);
      // R7 hold
      if (have_last) chk(sum_out == last_sum, "R7 sum_out hold", sum_out, last_sum);
    end
    exp_v[i] = 0;
    rst = r;
    if (r) for (int k = 0; k < RING; k++) exp_v[k] = 0;
    in_valid = v;
    x_in = W'(x); y_in = W'(y); z_in = W'(z);
    if (v && !r) begin
      o = (cyc + LAT + 1) % RING;
      exp_v[o]  = 1;
      exp_s[o]  = x + ((z == 0) ? ((1 << W) - 1) : (y / z));
      exp_dz[o] = (z == 0);
    end
    cyc++;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < RING; k++) begin exp_v[k] = 0; exp_s[k] = 0; exp_dz[k] = 0; end
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 1);
    // reset state
    @(negedge clk);
    chk(out_valid == 0, "R6 reset out_valid", out_valid, 0);
    chk(div_zero == 0, "R5 reset div_zero", div_zero, 0);
    // R2 latency constant
    chk(latency_out == LAT, "R2 latency_out", latency_out, LAT);
    // directed corners
    step(0, 1, 10, 100, 7);     // R1
    step(0, 1, 3, 5, 9);        // R1 y<z
    step(0, 1, 255, 255, 1);    // R8 max carry
    step(0, 1, 17, 200, 0);     // R4 zero divisor
    step(0, 1, 0, 0, 0);        // R4 zero/zero
    step(0, 1, 1, 255, 255);    // R1 quotient one
    step(0, 1, 255, 128, 0);    // R4 with carry
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 1);
    // back-to-back random with occasional zero divisors
    for (int k = 0; k < 200; k++)
      step(0, 1, $urandom_range(0, 255), $urandom_range(0, 255),
           ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 255));
    // sparse stream with gaps
    for (int k = 0; k < 200; k++)
      step(0, $urandom_range(0, 2) == 0, $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 255));
    // R6 mid-stream reset while sets keep arriving
    for (int k = 0; k < 3; k++) step(0, 1, k + 40, 250, 0);
    for (int k = 0; k < 2; k++) step(1, 1, 99, 99, 0);
    for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 1);
    step(0, 1, 7, 77, 7);
    for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 1);
    chk(latency_out == LAT, "R2 latency_out end", latency_out, LAT);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule